// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block keeps wall-clock time and a calendar in binary-coded decimal. A one-cycle enable at 64 Hz, synchronous to the system clock, feeds a six-stage prescaler. Each time the prescaler completes a second, a carry chain advances the time. The chain runs seconds, minutes and hours, then day of month and a free weekday count, then month and a two-digit year. A century bit flips whenever the year wraps. February gets 29 days when the year value is a multiple of four, and year 00 counts as one.

A register port writes and reads the seven time registers. Any write cycle restarts the prescaler phase. A stop input holds the prescaler at zero. After stop is released, the first second arrives after half a prescaler period. A freeze input, held by the reader across a multi-register read, keeps the image still. Ticks that arrive during a freeze are counted and applied afterwards. A low-supply input sets a sticky flag that only software can clear.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset, the registers read as follows. Address 0 (bit 7 = voltage-low flag, bits 6:0 = seconds) reads 0x80. Address 1 (minutes) and address 2 (hours) read 0x00. Address 3 (day) reads 0x01. Address 4 (weekday) reads 0x00. Address 5 (bit 7 = century, bits 4:0 = month) reads 0x01. Address 6 (year) and address 7 read 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59 and wrap to 00, each carrying into the next field. Hours count in BCD from 00 to 23 and carry into the day.
- R3: The day counts in BCD from 01 to the length of the current month, then returns to 01 and carries into the month. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. The weekday is binary 0 to 6 and advances with each day change, wrapping from 6 to 0.
- R4: February has 29 days when the BCD year is exactly divisible by 4, including year 00. Otherwise it has 28.
- R5: The month counts in BCD from 01 to 12, then returns to 01 and advances the BCD year. When the year wraps from 99 to 00, the century bit (bit 7 of address 5) toggles.
- R6: Starting from reset, from a stop release or from a write, the first second increment takes effect on the 32nd applied tick. Each later increment takes effect every 64 applied ticks.
- R7: While stop is high, the prescaler is held at zero, pending ticks are dropped and no time register advances.
- R8: A write stores only the implemented bits and sets the unused bits to zero (hours and day keep bits 5:0, weekday keeps bits 2:0, month keeps bits 4:0 plus the century bit 7). A write to address 7 changes nothing and address 7 reads 0x00. Every write cycle restarts the prescaler at zero and takes priority over an increment in the same cycle.
- R9: A high vlow_in sets the voltage-low flag on the next clock. The flag stays set until a write to address 0 with bit 7 low, and a vlow_in in the same cycle as that write wins.
- R10: While freeze is high, the time registers do not change except through writes. Ticks that arrive during a freeze are counted up to 2^PEND_W-1 (3 by default), and the rest are dropped. After release, the counted ticks are applied one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_64 | input | 1 | One-cycle 64 Hz time-base enable |
| stop | input | 1 | Holds the prescaler at zero and halts time |
| freeze | input | 1 | Holds the time image during a multi-register read |
| vlow_in | input | 1 | Low-supply indication, sets the sticky flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, combinational from the registers |

## Verification
The range properties assume that software only writes legal BCD values inside each field's range, with a day that fits the month then in force. The bench writes nothing else. The century property assumes tick_64 is a single-cycle pulse and that no write lands on the cycle of the wrap. The bench applies every tick as a one-cycle pulse and never writes while ticks are being applied. Freeze is raised only between register accesses, which matches how a reader uses it.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HR   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_WD   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_YR   = 3'd6;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [5:0] day;
    logic [2:0] wd;
    logic [4:0] mon;
    logic       cen;
    logic [7:0] yr;
  } cal_time_t;

  // Two-digit BCD increment, no wrap handling (callers decide wrap)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four on a BCD pair: (2*tens + units) mod 4 == 0
  function automatic logic leap_bcd(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last day of a BCD month, itself in BCD
  function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_W  = 6,
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop,
  input  logic freeze,
  input  logic clr,
  output logic sec_pulse
);
  localparam logic [DIV_W-1:0]  HALF     = DIV_W'((1 << (DIV_W - 1)) - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [DIV_W-1:0]  div_q;
  logic [PEND_W-1:0] pend_q;
  logic              pend_nz;
  logic              apply_tick;

  assign pend_nz    = (pend_q != '0);
  assign apply_tick = !stop && !freeze && (tick || pend_nz);
  assign sec_pulse  = apply_tick && (div_q == HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pend_q <= '0;
    end else if (stop) begin
      div_q  <= '0;
      pend_q <= '0;
    end else begin
      if (clr)             div_q <= '0;
      else if (apply_tick) div_q <= div_q + 1'b1;

      if (freeze) begin
        if (tick && pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
      end else if (pend_nz && !tick) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_pulse,
  input  logic              vlow_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cal_time_t         tm,
  output logic              vl_flag
);
  cal_time_t  nxt;
  logic       is_leap;
  logic [5:0] last_day;
  logic       wrap_sec, wrap_min, wrap_hr, wrap_day, wrap_mon, wrap_yr;

  assign is_leap  = leap_bcd(tm.yr);
  assign last_day = month_last_day(tm.mon, is_leap);
  assign wrap_sec = (tm.sec == 7'h59);
  assign wrap_min = (tm.min == 7'h59);
  assign wrap_hr  = (tm.hr  == 6'h23);
  assign wrap_day = (tm.day == last_day);
  assign wrap_mon = (tm.mon == 5'h12);
  assign wrap_yr  = (tm.yr  == 8'h99);

  always_comb begin
    nxt     = tm;
    nxt.sec = wrap_sec ? '0 : 7'(bcd_next({1'b0, tm.sec}));
    if (wrap_sec) begin
      nxt.min = wrap_min ? '0 : 7'(bcd_next({1'b0, tm.min}));
      if (wrap_min) begin
        nxt.hr = wrap_hr ? '0 : 6'(bcd_next({2'b0, tm.hr}));
        if (wrap_hr) begin
          nxt.wd  = (tm.wd == 3'd6) ? '0 : tm.wd + 3'd1;
          nxt.day = wrap_day ? 6'h01 : 6'(bcd_next({2'b0, tm.day}));
          if (wrap_day) begin
            nxt.mon = wrap_mon ? 5'h01 : 5'(bcd_next({3'b0, tm.mon}));
            if (wrap_mon) begin
              nxt.yr = wrap_yr ? '0 : bcd_next(tm.yr);
              if (wrap_yr) nxt.cen = ~tm.cen;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm      <= '{sec: 7'h00, min: 7'h00, hr: 6'h00, day: 6'h01,
                   wd: 3'd0, mon: 5'h01, cen: 1'b0, yr: 8'h00};
      vl_flag <= 1'b1;
    end else begin
      vl_flag <= vlow_in | ((wr_en && wr_addr == ADR_SEC) ? wr_data[7] : vl_flag);
      if (wr_en) begin
        case (wr_addr)
          ADR_SEC: tm.sec <= wr_data[6:0];
          ADR_MIN: tm.min <= wr_data[6:0];
          ADR_HR:  tm.hr  <= wr_data[5:0];
          ADR_DAY: tm.day <= wr_data[5:0];
          ADR_WD:  tm.wd  <= wr_data[2:0];
          ADR_MON: begin
            tm.cen <= wr_data[7];
            tm.mon <= wr_data[4:0];
          end
          ADR_YR:  tm.yr  <= wr_data;
          default: ;
        endcase
      end else if (sec_pulse) begin
        tm <= nxt;
      end
    end
  end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_64,
  input  logic              stop,
  input  logic              freeze,
  input  logic              vlow_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic      sec_pulse;
  cal_time_t tm;
  logic      vl_flag;

  cal_prescaler #(.DIV_W(DIV_W), .PEND_W(PEND_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_64),
    .stop      (stop),
    .freeze    (freeze),
    .clr       (wr_en),
    .sec_pulse (sec_pulse)
  );

  cal_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .vlow_in   (vlow_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tm        (tm),
    .vl_flag   (vl_flag)
  );

  always_comb begin
    case (rd_addr)
      ADR_SEC: rd_data = {vl_flag, tm.sec};
      ADR_MIN: rd_data = {1'b0, tm.min};
      ADR_HR:  rd_data = {2'b0, tm.hr};
      ADR_DAY: rd_data = {2'b0, tm.day};
      ADR_WD:  rd_data = {5'b0, tm.wd};
      ADR_MON: rd_data = {tm.cen, 2'b0, tm.mon};
      ADR_YR:  rd_data = tm.yr;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              freeze,
  input logic              vlow_in,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sec_pulse,
  input cal_time_t         tm,
  input logic              vl_flag
);

  a_r2_clock_range: assert property (@(posedge clk) disable iff (!rst_n)
    tm.sec[3:0] <= 4'd9 && tm.sec[6:4] <= 3'd5 &&
    tm.min[3:0] <= 4'd9 && tm.min[6:4] <= 3'd5 &&
    tm.hr[3:0]  <= 4'd9 && tm.hr <= 6'h23);

  a_r3_day_range: assert property (@(posedge clk) disable iff (!rst_n)
    tm.day >= 6'h01 && tm.day <= 6'h31 && tm.day[3:0] <= 4'd9 && tm.wd <= 3'd6);

  a_r5_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    tm.mon >= 5'h01 && tm.mon <= 5'h12 && tm.mon[3:0] <= 4'd9 &&
    tm.yr[3:0] <= 4'd9 && tm.yr[7:4] <= 4'd9);

  a_r5_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_en && tm.yr == 8'h99 && tm.mon == 5'h12 && tm.day == 6'h31 &&
     tm.hr == 6'h23 && tm.min == 7'h59 && tm.sec == 7'h59)
    |=> (tm.cen != $past(tm.cen)) && tm.yr == 8'h00);

  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !sec_pulse);

  a_r10_freeze_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !sec_pulse);

  a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(tm));

  a_r9_vl_set: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_in |=> vl_flag);

  a_r9_vl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_flag && !(wr_en && wr_addr == ADR_SEC)) |=> vl_flag);

endmodule

bind bcd_calendar_core bcd_calendar_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop      (stop),
  .freeze    (freeze),
  .vlow_in   (vlow_in),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .sec_pulse (sec_pulse),
  .tm        (tm),
  .vl_flag   (vl_flag)
);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int CLK_P = 10;
  localparam int NV    = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_64 = 1'b0;
  logic       stop = 1'b0;
  logic       freeze = 1'b0;
  logic       vlow_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bcd_calendar_core i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_64(tick_64), .stop(stop), .freeze(freeze),
    .vlow_in(vlow_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Byte order: sec, min, hr, day, weekday, century|month, year.
  // Start image, then image after exactly one second.
  localparam logic [111:0] VECS [NV] = '{
    {56'h56_34_12_15_03_06_21, 56'h57_34_12_15_03_06_21}, // R2 plain step
    {56'h59_00_00_15_03_06_21, 56'h00_01_00_15_03_06_21}, // R2 minute carry
    {56'h59_59_10_15_03_06_21, 56'h00_00_11_15_03_06_21}, // R2 hour carry
    {56'h59_59_23_15_06_06_21, 56'h00_00_00_16_00_06_21}, // R3 weekday 6->0
    {56'h59_59_23_30_02_04_21, 56'h00_00_00_01_03_05_21}, // R3 30-day month
    {56'h59_59_23_30_02_01_21, 56'h00_00_00_31_03_01_21}, // R3 31-day month
    {56'h59_59_23_28_01_02_21, 56'h00_00_00_01_02_03_21}, // R4 common Feb
    {56'h59_59_23_28_01_02_24, 56'h00_00_00_29_02_02_24}, // R4 leap Feb 28
    {56'h59_59_23_29_04_02_24, 56'h00_00_00_01_05_03_24}, // R4 leap Feb 29
    {56'h59_59_23_28_01_02_00, 56'h00_00_00_29_02_02_00}, // R4 year 00 leap
    {56'h59_59_23_31_05_12_99, 56'h00_00_00_01_06_81_00}, // R5 century 0->1
    {56'h59_59_23_31_05_92_99, 56'h00_00_00_01_06_01_00}, // R5 century 1->0
    {56'h59_59_23_31_05_12_09, 56'h00_00_00_01_06_01_10}, // R5 year BCD carry
    {56'h59_59_23_30_05_09_21, 56'h00_00_00_01_06_10_21}, // R5 month BCD carry
    {56'h59_59_23_28_05_02_10, 56'h00_00_00_01_06_03_10}, // R4 year 10 common
    {56'h59_59_23_28_05_02_12, 56'h00_00_00_29_06_02_12}, // R4 year 12 leap
    {56'h59_59_23_31_05_07_21, 56'h00_00_00_01_06_08_21}, // R3 July end
    {56'h59_59_23_31_05_08_21, 56'h00_00_00_01_06_09_21}  // R3 August end
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_64 = 1'b1;
      @(negedge clk); tick_64 = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int k = 0; k < 7; k++) wr(3'(k), t[55-8*k -: 8]);
  endtask

  task automatic get_time(output logic [55:0] t);
    logic [7:0] b;
    for (int k = 0; k < 7; k++) begin
      rd(3'(k), b);
      t[55-8*k -: 8] = b;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset image
    get_time(t);
    chk("R1 reset image", t, 56'h80_00_00_01_00_01_00);
    rd(3'd7, b);
    chk("R1 address 7", b, 8'h00);

    // R6 first second from reset after 32 ticks
    ticks(31);
    rd(3'd0, b);
    chk("R6 reset 31 ticks", b, 8'h80);
    ticks(1);
    rd(3'd0, b);
    chk("R6 reset 32 ticks", b, 8'h81);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      set_time(VECS[v][111:56]);
      ticks(32);
      get_time(t);
      chk($sformatf("R2/R3/R4/R5 vector %0d", v), t, VECS[v][55:0]);
    end

    // R6 steady spacing of 64 ticks
    set_time(56'h00_00_00_01_00_01_00);
    ticks(32);
    rd(3'd0, b);
    chk("R6 first step", b, 8'h01);
    ticks(63);
    rd(3'd0, b);
    chk("R6 63 ticks later", b, 8'h01);
    ticks(1);
    rd(3'd0, b);
    chk("R6 64 ticks later", b, 8'h02);

    // R8 write restarts prescaler phase
    ticks(20);
    wr(3'd1, 8'h05);
    ticks(31);
    get_time(t);
    chk("R8 after write 31 ticks", t, 56'h02_05_00_01_00_01_00);
    ticks(1);
    rd(3'd0, b);
    chk("R8 after write 32 ticks", b, 8'h03);

    // R8 unused bits dropped, address 7 ignored
    wr(3'd4, 8'hF5);
    rd(3'd4, b);
    chk("R8 weekday mask", b, 8'h05);
    wr(3'd2, 8'hE3);
    rd(3'd2, b);
    chk("R8 hours mask", b, 8'h23);
    wr(3'd5, 8'hE5);
    rd(3'd5, b);
    chk("R8 month mask", b, 8'h85);
    wr(3'd7, 8'hAA);
    rd(3'd7, b);
    chk("R8 address 7 read", b, 8'h00);
    get_time(t);
    chk("R8 address 7 no effect", t, 56'h03_05_23_01_05_85_00);

    // R7 stop holds time and restarts at half period
    set_time(56'h10_00_00_01_00_01_00);
    ticks(10);
    @(negedge clk); stop = 1'b1;
    ticks(100);
    rd(3'd0, b);
    chk("R7 stopped", b, 8'h10);
    @(negedge clk); stop = 1'b0;
    ticks(31);
    rd(3'd0, b);
    chk("R7 released 31 ticks", b, 8'h10);
    ticks(1);
    rd(3'd0, b);
    chk("R7 released 32 ticks", b, 8'h11);

    // R10 freeze holds image, pending ticks applied later
    set_time(56'h20_00_00_01_00_01_00);
    ticks(31);
    @(negedge clk); freeze = 1'b1;
    ticks(3);
    get_time(t);
    chk("R10 frozen image", t, 56'h20_00_00_01_00_01_00);
    @(negedge clk); freeze = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd0, b);
    chk("R10 pending applied", b, 8'h21);
    ticks(61);
    rd(3'd0, b);
    chk("R10 phase kept 61", b, 8'h21);
    ticks(1);
    rd(3'd0, b);
    chk("R10 phase kept 62", b, 8'h22);

    // R10 pending saturates at 3
    set_time(56'h30_00_00_01_00_01_00);
    @(negedge clk); freeze = 1'b1;
    ticks(5);
    @(negedge clk); freeze = 1'b0;
    repeat (4) @(negedge clk);
    ticks(28);
    rd(3'd0, b);
    chk("R10 saturated 28", b, 8'h30);
    ticks(1);
    rd(3'd0, b);
    chk("R10 saturated 29", b, 8'h31);

    // R9 voltage-low flag
    @(negedge clk); vlow_in = 1'b1;
    @(negedge clk); vlow_in = 1'b0;
    rd(3'd0, b);
    chk("R9 flag set", b, 8'hB1);
    wr(3'd1, 8'h07);
    rd(3'd0, b);
    chk("R9 sticky over other write", b, 8'hB1);
    wr(3'd0, 8'h31);
    rd(3'd0, b);
    chk("R9 cleared by write", b, 8'h31);
    @(negedge clk);
    vlow_in = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h31;
    @(negedge clk);
    vlow_in = 1'b0; wr_en = 1'b0;
    rd(3'd0, b);
    chk("R9 set wins over clear", b, 8'hB1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule